// File: doc/BRIEF.md
# UART Interrupt Identification Register

This block sits beside a UART's data path and gathers five interrupt events: receiver line status errors, received data available, receive time-out, transmit holding register empty and modem status change. Each event arrives as a one-cycle set pulse with its own enable bit. Once latched, an event stays pending until the host reads it out.

A host read port returns an 8-bit status byte. The low four bits encode the single highest-priority pending source. Bit 0 is an active-low pending flag. A read clears only the source that the byte reported, so any lower-priority source appears on the following read. The top two bits show whether the FIFO mode is enabled. An active-high request output stays asserted while any enabled source is pending.

Top module: `uart_isr`

## Requirements
- R1: After reset the status byte reads 0x01 (no pending source, FIFO bits 00) and `irq_o` is low.
- R2: The set-pulse bit positions and status bits [3:0] for each source are as follows. Bit 0 is line status and reads 0110. Bit 1 is data ready and reads 0100. Bit 2 is receive time-out and reads 1100. Bit 3 is transmit holding empty and reads 0010. Bit 4 is modem status and reads 0000. With nothing pending the bits read 0001.
- R3: Only the highest pending source is reported. The order, highest first, is line status, receive time-out, data ready, transmit holding empty, modem status.
- R4: A read (`rd_i` high for one cycle) clears only the source reported in that cycle. Every other pending source stays pending and shows on the next read.
- R5: An enabled set pulse latches its source. The source is visible in the status byte from the cycle after the pulse and remains pending until it is read.
- R6: A source whose enable bit is low when its pulse arrives is not latched. It never shows in the status byte and never raises `irq_o`.
- R7: `irq_o` is high exactly when status bit 0 reads 0, starting the cycle after an enabled pulse. It drops once no enabled source remains pending.
- R8: A set pulse on the source being cleared by a read in the same cycle wins, so that source stays pending.
- R9: Status bits [7:6] read 11 from the cycle after `fifo_mode_i` goes high and 00 when it is low. Bits [5:4] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 5 | One-cycle event pulses, bit per source |
| en_i | input | 5 | Per-source enables |
| fifo_mode_i | input | 1 | FIFO mode selected |
| rd_i | input | 1 | Status read strobe |
| stat_o | output | 8 | Interrupt identification byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default five sources. This keeps the full cross product within reach: all 32 enable masks against all 32 pending patterns. For each combination the bench drains the sources read by read, against a priority model computed in the bench, and checks every code and the request level. Directed cases cover the same-cycle set and clear race, the FIFO bits and a masked pulse that is later enabled.

// File: rtl/uart_isr_pkg.sv
package uart_isr_pkg;
  localparam int NSRC = 5;
  localparam int CW   = 4;

  typedef enum logic [2:0] {
    SRC_LS = 3'd0,
    SRC_RD = 3'd1,
    SRC_TO = 3'd2,
    SRC_TH = 3'd3,
    SRC_MS = 3'd4
  } src_e;

  localparam logic [CW-1:0] CODE_IDLE = 4'b0001;

  // rank 0 = highest priority
  function automatic src_e src_at_rank(input int r);
    case (r)
      0:       return SRC_LS;
      1:       return SRC_TO;
      2:       return SRC_RD;
      3:       return SRC_TH;
      default: return SRC_MS;
    endcase
  endfunction

  function automatic logic [CW-1:0] code_of(input src_e s);
    case (s)
      SRC_LS:  return 4'b0110;
      SRC_TO:  return 4'b1100;
      SRC_RD:  return 4'b0100;
      SRC_TH:  return 4'b0010;
      default: return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/uart_isr_srcbit.sv
module uart_isr_srcbit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic en_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;
  logic take;

  assign take = set_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q & ~clr_i) | take;
  end

  assign pend_o = pend_q;

  AST_SET_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> pend_q);  // R5
  AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && clr_i) |=> pend_q);  // R8
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !take) |=> !pend_q);  // R4
  AST_MASKED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !take) |=> !pend_q);  // R6
endmodule

// File: rtl/uart_isr_prio.sv
module uart_isr_prio
  import uart_isr_pkg::*;
(
  input  logic [NSRC-1:0] act_i,
  output logic [NSRC-1:0] sel_o,
  output logic [CW-1:0]   code_o
);
  always_comb begin
    sel_o  = '0;
    code_o = CODE_IDLE;
    // walk lowest rank last so the highest pending source overwrites
    for (int r = NSRC - 1; r >= 0; r--) begin
      if (act_i[src_at_rank(r)]) begin
        sel_o  = '0;
        sel_o[src_at_rank(r)] = 1'b1;
        code_o = code_of(src_at_rank(r));
      end
    end
  end
endmodule

// File: rtl/uart_isr.sv
module uart_isr
  import uart_isr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            fifo_mode_i,
  input  logic            rd_i,
  output logic [7:0]      stat_o,
  output logic            irq_o
);
  logic [NSRC-1:0] pend, act, sel, clr;
  logic [CW-1:0]   code;
  logic            fifo_q;

  assign act = pend & en_i;
  assign clr = sel & {NSRC{rd_i}};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    uart_isr_srcbit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_i[i]),
      .en_i   (en_i[i]),
      .clr_i  (clr[i]),
      .pend_o (pend[i])
    );
  end

  uart_isr_prio u_prio (
    .act_i  (act),
    .sel_o  (sel),
    .code_o (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fifo_q <= 1'b0;
    else         fifo_q <= fifo_mode_i;
  end

  assign stat_o = {{2{fifo_q}}, 2'b00, code};
  assign irq_o  = |act;

  AST_ONE_REPORTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));  // R3
  AST_IRQ_VS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == !stat_o[0]);  // R7
  AST_FIFO_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_mode_i |=> stat_o[7:6] == 2'b11);  // R9
  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[5:4] == 2'b00);  // R9
  AST_READ_ONE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && set_i == '0) |=> $countones(pend) + 1 >= $countones($past(pend)));  // R4
endmodule

// File: tb/uart_isr_test.sv
module uart_isr_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] set_i = '0;
  logic [4:0] en_i = '0;
  logic       fifo_mode_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] stat_o;
  logic       irq_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uart_isr uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i), .en_i(en_i),
    .fifo_mode_i(fifo_mode_i), .rd_i(rd_i), .stat_o(stat_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model: highest pending by stated order
  function automatic int top_src(input logic [4:0] m);
    if (m[0]) return 0;
    if (m[2]) return 2;
    if (m[1]) return 1;
    if (m[3]) return 3;
    if (m[4]) return 4;
    return -1;
  endfunction

  function automatic logic [3:0] exp_code(input int s);
    case (s)
      0: return 4'b0110;
      1: return 4'b0100;
      2: return 4'b1100;
      3: return 4'b0010;
      4: return 4'b0000;
      default: return 4'b0001;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk_i);
    set_i = m;
    @(negedge clk_i);
    set_i = '0;
  endtask

  task automatic read_once();
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 status", stat_o, 8'h01);
    chk("R1 irq", irq_o, 0);

    // R2 R3 R4 R5 R6 R7: sweep enables x pending patterns
    for (int e = 0; e < 32; e++) begin
      for (int s = 0; s < 32; s++) begin
        logic [4:0] m;
        do_reset();
        en_i = e[4:0];
        pulse(s[4:0]);
        m = e[4:0] & s[4:0];
        for (int k = 0; k < 6; k++) begin
          int t;
          t = top_src(m);
          chk("R3 code", stat_o[3:0], exp_code(t));
          chk("R7 irq", irq_o, (m != 0));
          read_once();
          if (t >= 0) m[t] = 1'b0;
        end
        chk("R4 drained", stat_o, 8'h01);
      end
    end

    // R6: masked pulse not latched even once enabled later
    do_reset();
    en_i = 5'b00000;
    pulse(5'b11111);
    en_i = 5'b11111;
    @(negedge clk_i);
    chk("R6 masked never latched", stat_o, 8'h01);
    chk("R6 irq low", irq_o, 0);

    // R5: stays pending across idle cycles
    pulse(5'b01000);
    repeat (5) @(negedge clk_i);
    chk("R5 held", stat_o[3:0], 4'b0010);

    // R8: same-cycle set and clear on the reported source
    rd_i = 1'b1;
    set_i = 5'b01000;
    @(negedge clk_i);
    rd_i = 1'b0;
    set_i = '0;
    chk("R8 set wins", stat_o[3:0], 4'b0010);
    read_once();
    chk("R8 then cleared", stat_o[3:0], 4'b0001);

    // R9: fifo bits
    fifo_mode_i = 1'b1;
    @(negedge clk_i);
    chk("R9 fifo on", stat_o, 8'hC1);
    pulse(5'b00100);
    chk("R9 with code", stat_o, 8'hCC);
    fifo_mode_i = 1'b0;
    @(negedge clk_i);
    chk("R9 fifo off", stat_o, 8'h0C);
    do_reset();
    chk("R1 fifo cleared", stat_o, 8'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule